// File: doc/BRIEF.md
# Packet Link Efficiency Monitor

This block observes the two directions of a packetized memory link: the request direction and the response direction. Each accepted packet is reported by a one-cycle strobe with its command kind and payload length. The block counts link FLITs (16-byte units) for each direction. It keeps two counts per direction: a total count that includes the single overhead FLIT every packet carries, and an effective count of payload FLITs only. All four live counters saturate at all ones.

A programmable window, counted in clock cycles, sets the measurement period. On the last cycle of a window the live counters are copied into snapshot registers, and that copy includes the packets of that cycle. The live counters then restart from zero. One cycle after each snapshot, a divider per direction begins to compute the efficiency ratio `effective * 1024 / total`. A done flag rises once both results are ready.

Each divider is a three-state machine. The states are DV_IDLE (after reset), DV_RUN (shifting one quotient bit per cycle) and DV_DONE (result held). The transitions are as follows. A start moves any state to DV_RUN, or straight to DV_DONE when the divisor is zero. DV_RUN moves to DV_DONE after its last quotient bit. DV_DONE stays in place until the next start.

Top module: `flit_eff_mon`

## Requirements
- R1: A request-direction strobe of kind 1 (write request) adds len_m1+2 to the request total and len_m1+1 to the request effective count. The len_m1 field is the number of payload FLITs minus one (0..7 means 1..8 FLITs).
- R2: A strobe whose kind does not carry payload on its direction adds exactly 1 to that direction's total and 0 to its effective count. This covers kind 0 (read request) and kind 3 (write response), and any response kind seen on the request side or request kind seen on the response side.
- R3: A response-direction strobe of kind 2 (read response) adds len_m1+2 to the response total and len_m1+1 to the response effective count.
- R4: Each live counter saturates at all ones and never wraps. The effective count never exceeds the total of the same direction.
- R5: A window ends on the cycle in which the elapsed cycle count since the last end (or since reset) reaches win_cycles; a value of 0 acts as 1. In that cycle the snapshot outputs take the counter values including that cycle's packets, and the live counters read zero after the edge. snap_pulse is high for exactly the cycle after the edge.
- R6: After a snapshot, each ratio output equals floor(snap_eff*1024/snap_total), or 0 when snap_total is 0. ratio_done is high CNT_W+11 clock edges after the window-end edge.
- R7: ratio_done is low while a division runs. A window that ends before the division completes restarts the division, so with windows shorter than the division time ratio_done never rises.
- R8: After reset all counters, snapshots, ratios, snap_pulse and ratio_done are zero.
- R9: A strobe held low adds nothing, whatever its kind and length fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_cycles | input | 32 | Window length in cycles |
| req_strobe | input | 1 | Request-direction packet valid |
| req_kind | input | 2 | Command kind: 0 read req, 1 write req, 2 read rsp, 3 write rsp |
| req_len_m1 | input | 3 | Payload FLITs minus one |
| rsp_strobe | input | 1 | Response-direction packet valid |
| rsp_kind | input | 2 | Command kind, same encoding |
| rsp_len_m1 | input | 3 | Payload FLITs minus one |
| live_req_total | output | CNT_W | Running request total FLITs |
| live_req_eff | output | CNT_W | Running request payload FLITs |
| live_rsp_total | output | CNT_W | Running response total FLITs |
| live_rsp_eff | output | CNT_W | Running response payload FLITs |
| snap_req_total | output | CNT_W | Request total at last window end |
| snap_req_eff | output | CNT_W | Request payload at last window end |
| snap_rsp_total | output | CNT_W | Response total at last window end |
| snap_rsp_eff | output | CNT_W | Response payload at last window end |
| snap_pulse | output | 1 | High one cycle after a snapshot |
| req_ratio | output | 11 | Request efficiency ×1024 |
| rsp_ratio | output | 11 | Response efficiency ×1024 |
| ratio_done | output | 1 | Both ratios valid |

## Verification
A wrong increment or a missed saturation appears on the live counters at the very next edge. The bench compares them against its own arithmetic model every cycle. A window timer that is off by one cycle moves snap_pulse and the snapshot contents, and this shows within one window. A divider fault shows up as a wrong ratio, or as a done flag one edge early or late, after a fixed CNT_W+11 edges from the window end.

// File: rtl/flit_mon_pkg.sv
package flit_mon_pkg;

    typedef enum logic [1:0] {
        PK_RD_REQ = 2'd0,
        PK_WR_REQ = 2'd1,
        PK_RD_RSP = 2'd2,
        PK_WR_RSP = 2'd3
    } pkt_kind_e;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_DONE = 2'd2
    } div_state_e;

    localparam int unsigned RATIO_SHIFT = 10;
    localparam int unsigned RATIO_W     = RATIO_SHIFT + 1;
    localparam int unsigned LEN_W       = 3;

endpackage

// File: rtl/flit_dir_counter.sv
module flit_dir_counter
    import flit_mon_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter pkt_kind_e   PAY_KIND = PK_WR_REQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [1:0]       kind,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             win_end,
    output logic [CNT_W-1:0] live_tot,
    output logic [CNT_W-1:0] live_eff,
    output logic [CNT_W-1:0] snap_tot,
    output logic [CNT_W-1:0] snap_eff
);
    localparam int unsigned INC_W = LEN_W + 1;

    logic             carries;
    logic [INC_W-1:0] pay_flits;
    logic [INC_W-1:0] inc_tot;
    logic [INC_W-1:0] inc_eff;
    logic [CNT_W:0]   sum_tot;
    logic [CNT_W:0]   sum_eff;
    logic [CNT_W-1:0] nxt_tot;
    logic [CNT_W-1:0] nxt_eff;

    always_comb begin
        carries   = strobe && (pkt_kind_e'(kind) == PAY_KIND);
        pay_flits = {1'b0, len_m1} + INC_W'(1);
        inc_tot   = !strobe ? '0 : (carries ? pay_flits + INC_W'(1) : INC_W'(1));
        inc_eff   = carries ? pay_flits : '0;
        sum_tot   = {1'b0, live_tot} + (CNT_W+1)'(inc_tot);
        sum_eff   = {1'b0, live_eff} + (CNT_W+1)'(inc_eff);
        nxt_tot   = sum_tot[CNT_W] ? '1 : sum_tot[CNT_W-1:0];
        nxt_eff   = sum_eff[CNT_W] ? '1 : sum_eff[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_tot <= '0;
            live_eff <= '0;
            snap_tot <= '0;
            snap_eff <= '0;
        end else if (win_end) begin
            live_tot <= '0;
            live_eff <= '0;
            snap_tot <= nxt_tot;
            snap_eff <= nxt_eff;
        end else begin
            live_tot <= nxt_tot;
            live_eff <= nxt_eff;
        end
    end

endmodule

// File: rtl/flit_ratio_div.sv
module flit_ratio_div
    import flit_mon_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   num,
    input  logic [CNT_W-1:0]   den,
    output logic               done,
    output logic [RATIO_W-1:0] quo
);
    localparam int unsigned DW = CNT_W + RATIO_SHIFT;
    localparam int unsigned SW = $clog2(DW + 1);

    div_state_e       state, state_nxt;
    logic [CNT_W:0]   rem;
    logic [CNT_W:0]   rem_sh;
    logic [CNT_W:0]   rem_nxt;
    logic [DW-1:0]    dvd;
    logic [DW-1:0]    q;
    logic [CNT_W-1:0] den_q;
    logic [SW-1:0]    step;
    logic             qbit;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DV_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            DV_IDLE: if (start) state_nxt = (den == '0) ? DV_DONE : DV_RUN;
            DV_RUN: begin
                if (start)                        state_nxt = (den == '0) ? DV_DONE : DV_RUN;
                else if (step == SW'(DW - 1))     state_nxt = DV_DONE;
            end
            DV_DONE: if (start) state_nxt = (den == '0) ? DV_DONE : DV_RUN;
            default: state_nxt = DV_IDLE;
        endcase
    end

    always_comb begin
        rem_sh  = {rem[CNT_W-1:0], dvd[DW-1]};
        qbit    = rem_sh >= {1'b0, den_q};
        rem_nxt = qbit ? rem_sh - {1'b0, den_q} : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            dvd   <= '0;
            q     <= '0;
            den_q <= '0;
            step  <= '0;
        end else if (start) begin
            rem   <= '0;
            dvd   <= {num, {RATIO_SHIFT{1'b0}}};
            q     <= '0;
            den_q <= den;
            step  <= '0;
        end else if (state == DV_RUN) begin
            rem   <= rem_nxt;
            dvd   <= {dvd[DW-2:0], 1'b0};
            q     <= {q[DW-2:0], qbit};
            step  <= step + SW'(1);
        end
    end

    assign done = (state == DV_DONE);
    assign quo  = q[RATIO_W-1:0];

endmodule

// File: rtl/flit_eff_mon.sv
module flit_eff_mon
    import flit_mon_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned WIN_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIN_W-1:0]   win_cycles,
    input  logic               req_strobe,
    input  logic [1:0]         req_kind,
    input  logic [2:0]         req_len_m1,
    input  logic               rsp_strobe,
    input  logic [1:0]         rsp_kind,
    input  logic [2:0]         rsp_len_m1,
    output logic [CNT_W-1:0]   live_req_total,
    output logic [CNT_W-1:0]   live_req_eff,
    output logic [CNT_W-1:0]   live_rsp_total,
    output logic [CNT_W-1:0]   live_rsp_eff,
    output logic [CNT_W-1:0]   snap_req_total,
    output logic [CNT_W-1:0]   snap_req_eff,
    output logic [CNT_W-1:0]   snap_rsp_total,
    output logic [CNT_W-1:0]   snap_rsp_eff,
    output logic               snap_pulse,
    output logic [10:0]        req_ratio,
    output logic [10:0]        rsp_ratio,
    output logic               ratio_done
);
    localparam int unsigned NDIR = 2;

    logic [WIN_W-1:0] wcnt;
    logic [WIN_W:0]   elapsed;
    logic             win_end;

    logic [NDIR-1:0]                dir_strobe;
    logic [NDIR-1:0][1:0]           dir_kind;
    logic [NDIR-1:0][LEN_W-1:0]     dir_len;
    logic [NDIR-1:0][CNT_W-1:0]     d_live_tot, d_live_eff, d_snap_tot, d_snap_eff;
    logic [NDIR-1:0][RATIO_W-1:0]   d_ratio;
    logic [NDIR-1:0]                d_done;

    // window timer: end when the elapsed count reaches the programmed length
    assign elapsed = {1'b0, wcnt} + (WIN_W+1)'(1);
    assign win_end = elapsed >= {1'b0, win_cycles};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt       <= '0;
            snap_pulse <= 1'b0;
        end else begin
            wcnt       <= win_end ? '0 : wcnt + WIN_W'(1);
            snap_pulse <= win_end;
        end
    end

    assign dir_strobe = {rsp_strobe, req_strobe};
    assign dir_kind   = {rsp_kind, req_kind};
    assign dir_len    = {rsp_len_m1, req_len_m1};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        localparam pkt_kind_e PK = (d == 0) ? PK_WR_REQ : PK_RD_RSP;

        flit_dir_counter #(.CNT_W(CNT_W), .PAY_KIND(PK)) cnt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe   (dir_strobe[d]),
            .kind     (dir_kind[d]),
            .len_m1   (dir_len[d]),
            .win_end  (win_end),
            .live_tot (d_live_tot[d]),
            .live_eff (d_live_eff[d]),
            .snap_tot (d_snap_tot[d]),
            .snap_eff (d_snap_eff[d])
        );

        flit_ratio_div #(.CNT_W(CNT_W)) div_i (
            .clk   (clk),
            .rst_n (rst_n),
            .start (snap_pulse),
            .num   (d_snap_eff[d]),
            .den   (d_snap_tot[d]),
            .done  (d_done[d]),
            .quo   (d_ratio[d])
        );
    end

    assign live_req_total = d_live_tot[0];
    assign live_req_eff   = d_live_eff[0];
    assign live_rsp_total = d_live_tot[1];
    assign live_rsp_eff   = d_live_eff[1];
    assign snap_req_total = d_snap_tot[0];
    assign snap_req_eff   = d_snap_eff[0];
    assign snap_rsp_total = d_snap_tot[1];
    assign snap_rsp_eff   = d_snap_eff[1];
    assign req_ratio      = d_ratio[0];
    assign rsp_ratio      = d_ratio[1];
    assign ratio_done     = &d_done;

endmodule

// File: rtl/flit_eff_mon_chk.sv
module flit_eff_mon_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_strobe,
    input logic             rsp_strobe,
    input logic             win_end,
    input logic             snap_pulse,
    input logic [CNT_W-1:0] live_req_total,
    input logic [CNT_W-1:0] live_req_eff,
    input logic [CNT_W-1:0] live_rsp_total,
    input logic [CNT_W-1:0] live_rsp_eff,
    input logic [CNT_W-1:0] snap_req_total,
    input logic [10:0]      req_ratio,
    input logic [10:0]      rsp_ratio,
    input logic             ratio_done
);
    p_req_eff_le_tot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live_req_eff <= live_req_total);

    p_rsp_eff_le_tot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live_rsp_eff <= live_rsp_total);

    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_req_total == '1) && !win_end |=> live_req_total == '1);

    p_clear_on_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (live_req_total == '0) && (live_rsp_total == '0) && snap_pulse);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_strobe && !rsp_strobe && !win_end |=>
            $stable(live_req_total) && $stable(live_rsp_total));

    p_ratio_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_done |-> (req_ratio <= 11'd1024) && (rsp_ratio <= 11'd1024));

    p_restart_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snap_pulse && (snap_req_total != '0) |=> !ratio_done);

endmodule

bind flit_eff_mon flit_eff_mon_chk #(.CNT_W(CNT_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_strobe     (req_strobe),
    .rsp_strobe     (rsp_strobe),
    .win_end        (win_end),
    .snap_pulse     (snap_pulse),
    .live_req_total (live_req_total),
    .live_req_eff   (live_req_eff),
    .live_rsp_total (live_rsp_total),
    .live_rsp_eff   (live_rsp_eff),
    .snap_req_total (snap_req_total),
    .req_ratio      (req_ratio),
    .rsp_ratio      (rsp_ratio),
    .ratio_done     (ratio_done)
);

// File: tb/flit_eff_mon_tb.sv
module flit_eff_mon_tb_top;
    localparam int CW   = 8;
    localparam int DW   = CW + 10;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [31:0]   win_cycles;
    logic          req_strobe, rsp_strobe;
    logic [1:0]    req_kind, rsp_kind;
    logic [2:0]    req_len_m1, rsp_len_m1;
    logic [CW-1:0] live_req_total, live_req_eff, live_rsp_total, live_rsp_eff;
    logic [CW-1:0] snap_req_total, snap_req_eff, snap_rsp_total, snap_rsp_eff;
    logic          snap_pulse, ratio_done;
    logic [10:0]   req_ratio, rsp_ratio;

    always #10 clk = ~clk;

    flit_eff_mon #(.CNT_W(CW), .WIN_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .win_cycles(win_cycles),
        .req_strobe(req_strobe), .req_kind(req_kind), .req_len_m1(req_len_m1),
        .rsp_strobe(rsp_strobe), .rsp_kind(rsp_kind), .rsp_len_m1(rsp_len_m1),
        .live_req_total(live_req_total), .live_req_eff(live_req_eff),
        .live_rsp_total(live_rsp_total), .live_rsp_eff(live_rsp_eff),
        .snap_req_total(snap_req_total), .snap_req_eff(snap_req_eff),
        .snap_rsp_total(snap_rsp_total), .snap_rsp_eff(snap_rsp_eff),
        .snap_pulse(snap_pulse), .req_ratio(req_ratio), .rsp_ratio(rsp_ratio),
        .ratio_done(ratio_done)
    );

    int checks = 0;
    int errors = 0;
    int m_rt, m_re, m_st, m_se;
    int s_rt, s_re, s_st, s_se;
    int m_w, m_k, win;
    bit expect_nodone = 1'b0;
    logic [31:0] lf = 32'h1ACE_B00C;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    function automatic int ratio_of(input int e, input int t);
        return (t == 0) ? 0 : (e * 1024) / t;
    endfunction

    task automatic do_reset(input int w);
        rst_n = 1'b0;
        req_strobe = 1'b0; rsp_strobe = 1'b0;
        req_kind = 2'd0; rsp_kind = 2'd0; req_len_m1 = 3'd0; rsp_len_m1 = 3'd0;
        win_cycles = 32'(w);
        win = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_rt = 0; m_re = 0; m_st = 0; m_se = 0;
        s_rt = 0; s_re = 0; s_st = 0; s_se = 0;
        m_w = 0; m_k = -1;
    endtask

    // drive at negedge, model the posedge, compare 1 ns after it
    task automatic step(input int rv, input int rk, input int rl,
                        input int sv, input int sk, input int sl, input string tag);
        bit ended;
        req_strobe = rv[0]; req_kind = rk[1:0]; req_len_m1 = rl[2:0];
        rsp_strobe = sv[0]; rsp_kind = sk[1:0]; rsp_len_m1 = sl[2:0];
        @(posedge clk);
        if (rv != 0) begin
            if (rk == 1) begin m_rt = sat(m_rt + rl + 2); m_re = sat(m_re + rl + 1); end
            else m_rt = sat(m_rt + 1);
        end
        if (sv != 0) begin
            if (sk == 2) begin m_st = sat(m_st + sl + 2); m_se = sat(m_se + sl + 1); end
            else m_st = sat(m_st + 1);
        end
        ended = (m_w + 1 >= win);
        if (ended) begin
            s_rt = m_rt; s_re = m_re; s_st = m_st; s_se = m_se;
            m_rt = 0; m_re = 0; m_st = 0; m_se = 0;
            m_w = 0; m_k = 0;
        end else begin
            m_w++;
            if (m_k >= 0) m_k++;
        end
        #1;
        chk({tag, " live_req_total"}, int'(live_req_total), m_rt);
        chk({tag, " live_req_eff"},   int'(live_req_eff),   m_re);
        chk({tag, " live_rsp_total"}, int'(live_rsp_total), m_st);
        chk({tag, " live_rsp_eff"},   int'(live_rsp_eff),   m_se);
        chk("R5 snap_pulse", int'(snap_pulse), int'(ended));
        if (ended) begin
            chk("R5 snap_req_total", int'(snap_req_total), s_rt);
            chk("R5 snap_req_eff",   int'(snap_req_eff),   s_re);
            chk("R5 snap_rsp_total", int'(snap_rsp_total), s_st);
            chk("R5 snap_rsp_eff",   int'(snap_rsp_eff),   s_se);
        end
        if (expect_nodone) chk("R7 done stays low on restart", int'(ratio_done), 0);
        if (m_k == DW && !(s_rt == 0 && s_st == 0))
            chk("R7 done low during divide", int'(ratio_done), 0);
        if (m_k == DW + 1) begin
            chk("R6 ratio_done", int'(ratio_done), 1);
            chk("R6 req_ratio", int'(req_ratio), ratio_of(s_re, s_rt));
            chk("R6 rsp_ratio", int'(rsp_ratio), ratio_of(s_se, s_st));
        end
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        do_reset(1000);
        chk("R8 live_req_total", int'(live_req_total), 0);
        chk("R8 live_rsp_total", int'(live_rsp_total), 0);
        chk("R8 snap_req_total", int'(snap_req_total), 0);
        chk("R8 snap_rsp_eff",   int'(snap_rsp_eff),   0);
        chk("R8 snap_pulse",     int'(snap_pulse),     0);
        chk("R8 ratio_done",     int'(ratio_done),     0);
        chk("R8 req_ratio",      int'(req_ratio),      0);

        // exhaustive kind x length sweep on both directions, with idle strobes (R9)
        for (int k = 0; k < 4; k++) begin
            do_reset(1000);
            for (int l = 0; l < 8; l++) begin
                step(1, k, l, 1, 3 - k, 7 - l,
                     (k == 1) ? "R1" : ((k == 2) ? "R3" : "R2"));
                step(0, k, l, 0, 3 - k, l, "R9");
            end
        end

        // mixed traffic over windows of 25 cycles: snapshots and ratios
        do_reset(25);
        for (int i = 0; i < 300; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(int'(lf[0] | lf[9]), int'(lf[2:1]), int'(lf[5:3]),
                 int'(lf[6]), int'(lf[8:7]), int'(lf[12:10]), "R5");
        end

        // idle windows: zero totals give ratio 0
        do_reset(30);
        for (int i = 0; i < 70; i++) step(0, 1, 7, 0, 2, 7, "R6");

        // a window length of 0 ends a window every cycle
        do_reset(0);
        for (int i = 0; i < 12; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(1, int'(lf[1:0]), int'(lf[4:2]), 1, int'(lf[6:5]), int'(lf[9:7]), "R5");
        end

        // windows shorter than the divide keep restarting it
        do_reset(10);
        step(1, 1, 3, 1, 2, 5, "R7");
        expect_nodone = 1'b1;
        for (int i = 0; i < 60; i++) step(1, 1, 3, 1, 2, 5, "R7");
        expect_nodone = 1'b0;

        // saturation under continuous maximum-size traffic
        do_reset(200);
        for (int i = 0; i < 60; i++) step(1, 1, 7, 1, 2, 7, "R4");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule